// File: doc/BRIEF.md
# Address-Space-Tagged Set-Associative Translation Cache

This block caches translations from virtual page numbers to physical frame numbers for 4KB pages. A lookup carries a full virtual address and the address-space identifier of the running process. The low bits of the page number pick a set, every way of that set is compared at once, and on the following cycle the block reports a hit with the physical address (frame number joined to the untouched 12-bit offset) or raises a one-cycle miss pulse carrying the page number and identifier that missed, so that a page walker can fetch the mapping.

The walker returns its result through the fill port. Because every entry stores an identifier next to its tag, translations of several processes live side by side and a context switch needs no flush. Software-driven maintenance is served by two commands: a single-page invalidate, which removes only the entry whose page number and identifier both match, and a flush-all, which empties the whole cache.

Top module: `tlb_asid_cache`

## Requirements
- R1: The set index is the low log2(SETS) bits of the virtual page number (address bits above the 12-bit offset); all ways of that set are compared, and a way hits only when it is valid and its stored page number matches the request; a fill into one set leaves the entries of every other set unchanged.
- R2: Results are registered: a lookup presented with lk_valid high in cycle t is answered on lk_hit, lk_paddr, lk_writable and miss_pulse in cycle t+1, and a cycle without a lookup gives lk_hit=0 and miss_pulse=0 in the next cycle.
- R3: A hit also requires the stored identifier to equal lk_asid; the same page number under a different identifier misses, and two identifiers may hold different frames for one page number at the same time.
- R4: On a hit lk_paddr equals {stored frame number, the request's 12-bit offset} and lk_writable returns the stored write flag; without a hit both are zero.
- R5: A lookup that misses gives exactly one cycle of miss_pulse, with miss_vpn and miss_asid equal to the request's page number and identifier; lk_hit and miss_pulse are never high together.
- R6: A fill whose page number and identifier already sit in the set overwrites that way; otherwise it takes the lowest-numbered invalid way; otherwise it replaces the way named by that set's rotation pointer, which starts at 0 and then advances by one, wrapping after the last way; only replacements of this last kind move the pointer.
- R7: A single-page invalidate clears only the entry matching both inv_vpn and inv_asid; an entry with the same page number but another identifier stays valid.
- R8: A flush-all clears the valid flag of every entry in every set.
- R9: When a fill arrives in the same cycle as a flush-all, or as a single-page invalidate naming the same page number and identifier, the fill is dropped and the entry is not present afterwards.
- R10: After reset every entry is invalid and lk_hit, miss_pulse and lk_paddr are zero.
- R11: A fill or invalidate in cycle t changes what lookups presented from cycle t+1 see; a lookup in cycle t itself sees the entries as they were before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | VPN_W+OFS_W | Virtual address to translate |
| lk_asid | input | ASID_W | Address-space identifier of the request |
| lk_hit | output | 1 | Registered hit flag |
| lk_paddr | output | PFN_W+OFS_W | Physical address of the hit, zero otherwise |
| lk_writable | output | 1 | Stored write flag of the hit entry |
| miss_pulse | output | 1 | One-cycle miss indication |
| miss_vpn | output | VPN_W | Page number that missed |
| miss_asid | output | ASID_W | Identifier that missed |
| fill_valid | input | 1 | Fill strobe from the page walker |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Identifier to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_writable | input | 1 | Write flag to install |
| inv_page | input | 1 | Single-page invalidate strobe |
| inv_vpn | input | VPN_W | Page number to invalidate |
| inv_asid | input | ASID_W | Identifier to invalidate |
| inv_all | input | 1 | Flush-all strobe |

## Verification
The bench builds the block with its defaults: four sets of two ways, 36-bit page numbers, 8-bit identifiers and 24-bit frame numbers. With only two ways a third distinct page in one set already forces a rotating replacement, so eviction order, pointer wrap and in-place refill are reached within a few fills, and a random page pool of 24 numbers over two identifiers keeps sets full and hit rates high enough to mix hits, misses, evictions and same-cycle fill/invalidate collisions.

// File: rtl/tlbc_pkg.sv
package tlbc_pkg;

   typedef enum logic [1:0] {
      PICK_NONE,
      PICK_MATCH,
      PICK_FREE,
      PICK_ROTATE
   } pick_kind_e;

   function automatic int unsigned ptr_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/tlbc_way_cmp.sv
module tlbc_way_cmp #(
   parameter int unsigned TAG_W  = 34,
   parameter int unsigned ASID_W = 8
) (
   input  logic              ent_valid,
   input  logic [TAG_W-1:0]  ent_tag,
   input  logic [ASID_W-1:0] ent_asid,
   input  logic [TAG_W-1:0]  key_tag,
   input  logic [ASID_W-1:0] key_asid,
   output logic              match
);

   assign match = ent_valid && (ent_tag == key_tag) && (ent_asid == key_asid);

endmodule

// File: rtl/tlbc_rr_ptr.sv
module tlbc_rr_ptr #(
   parameter int unsigned WAYS  = 2,
   parameter int unsigned PTR_W = tlbc_pkg::ptr_width(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [PTR_W-1:0] ptr
);

   localparam bit POW2 = (WAYS == (1 << PTR_W));

   generate
      if (POW2) begin : g_wrap_free
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    ptr <= '0;
            else if (step) ptr <= ptr + 1'b1;
         end
      end else begin : g_wrap_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    ptr <= '0;
            else if (step) ptr <= (ptr == PTR_W'(WAYS - 1)) ? '0 : ptr + 1'b1;
         end
      end
   endgenerate

   assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(ptr));

   assert_ptr_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> !$stable(ptr));

endmodule

// File: rtl/tlbc_fill_pick.sv
module tlbc_fill_pick
   import tlbc_pkg::*;
#(
   parameter int unsigned WAYS  = 2,
   parameter int unsigned PTR_W = tlbc_pkg::ptr_width(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [WAYS-1:0]  valid_vec,
   input  logic [WAYS-1:0]  match_vec,
   input  logic [PTR_W-1:0] rr_ptr,
   output logic [WAYS-1:0]  way_oh,
   output pick_kind_e       kind
);

   always_comb begin
      logic found;
      found  = 1'b0;
      way_oh = '0;
      kind   = PICK_NONE;
      if (|match_vec) begin
         way_oh = match_vec;
         kind   = PICK_MATCH;
      end else if (!(&valid_vec)) begin
         kind = PICK_FREE;
         for (int w = 0; w < WAYS; w++) begin
            if (!valid_vec[w] && !found) begin
               way_oh[w] = 1'b1;
               found     = 1'b1;
            end
         end
      end else begin
         kind           = PICK_ROTATE;
         way_oh[rr_ptr] = 1'b1;
      end
   end

   // A set never holds the same translation twice, so the choice is one way.
   assert_pick_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> $onehot(way_oh));

   assert_pick_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && kind == PICK_FREE) |-> ((way_oh & valid_vec) == '0));

endmodule

// File: rtl/tlb_asid_cache.sv
module tlb_asid_cache
   import tlbc_pkg::*;
#(
   parameter int unsigned SETS   = 4,
   parameter int unsigned WAYS   = 2,
   parameter int unsigned VPN_W  = 36,
   parameter int unsigned ASID_W = 8,
   parameter int unsigned PFN_W  = 24,
   parameter int unsigned OFS_W  = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    lk_valid,
   input  logic [VPN_W+OFS_W-1:0]  lk_vaddr,
   input  logic [ASID_W-1:0]       lk_asid,
   output logic                    lk_hit,
   output logic [PFN_W+OFS_W-1:0]  lk_paddr,
   output logic                    lk_writable,
   output logic                    miss_pulse,
   output logic [VPN_W-1:0]        miss_vpn,
   output logic [ASID_W-1:0]       miss_asid,
   input  logic                    fill_valid,
   input  logic [VPN_W-1:0]        fill_vpn,
   input  logic [ASID_W-1:0]       fill_asid,
   input  logic [PFN_W-1:0]        fill_pfn,
   input  logic                    fill_writable,
   input  logic                    inv_page,
   input  logic [VPN_W-1:0]        inv_vpn,
   input  logic [ASID_W-1:0]       inv_asid,
   input  logic                    inv_all
);

   localparam int unsigned VA_W  = VPN_W + OFS_W;
   localparam int unsigned PA_W  = PFN_W + OFS_W;
   localparam int unsigned IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
   localparam int unsigned TAG_W = VPN_W - IDX_W;
   localparam int unsigned PTR_W = ptr_width(WAYS);

   generate
      if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
         $error("tlb_asid_cache: SETS must be a power of two, at least 2");
      end
      if (WAYS < 2) begin : g_bad_ways
         $error("tlb_asid_cache: WAYS must be at least 2");
      end
      if (VPN_W <= IDX_W) begin : g_bad_vpn
         $error("tlb_asid_cache: VPN_W must exceed the set index width");
      end
   endgenerate

   // ---------------- entry storage ----------------
   logic [WAYS-1:0]   ent_v    [SETS];
   logic [TAG_W-1:0]  ent_tag  [SETS][WAYS];
   logic [ASID_W-1:0] ent_asid [SETS][WAYS];
   logic [PFN_W-1:0]  ent_pfn  [SETS][WAYS];
   logic              ent_wr   [SETS][WAYS];

   // ---------------- key split ----------------
   logic [VPN_W-1:0] l_vpn;
   logic [IDX_W-1:0] l_set, f_set, i_set;
   logic [TAG_W-1:0] l_tag, f_tag, i_tag;

   assign l_vpn = lk_vaddr[VA_W-1:OFS_W];
   assign l_set = l_vpn[IDX_W-1:0];
   assign l_tag = l_vpn[VPN_W-1:IDX_W];
   assign f_set = fill_vpn[IDX_W-1:0];
   assign f_tag = fill_vpn[VPN_W-1:IDX_W];
   assign i_set = inv_vpn[IDX_W-1:0];
   assign i_tag = inv_vpn[VPN_W-1:IDX_W];

   // ---------------- parallel way compare ----------------
   logic [WAYS-1:0] l_hit_vec, f_match_vec, i_match_vec;

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         tlbc_way_cmp #(.TAG_W(TAG_W), .ASID_W(ASID_W)) u_cmp_lk (
            .ent_valid (ent_v[l_set][w]),
            .ent_tag   (ent_tag[l_set][w]),
            .ent_asid  (ent_asid[l_set][w]),
            .key_tag   (l_tag),
            .key_asid  (lk_asid),
            .match     (l_hit_vec[w])
         );
         tlbc_way_cmp #(.TAG_W(TAG_W), .ASID_W(ASID_W)) u_cmp_fill (
            .ent_valid (ent_v[f_set][w]),
            .ent_tag   (ent_tag[f_set][w]),
            .ent_asid  (ent_asid[f_set][w]),
            .key_tag   (f_tag),
            .key_asid  (fill_asid),
            .match     (f_match_vec[w])
         );
         tlbc_way_cmp #(.TAG_W(TAG_W), .ASID_W(ASID_W)) u_cmp_inv (
            .ent_valid (ent_v[i_set][w]),
            .ent_tag   (ent_tag[i_set][w]),
            .ent_asid  (ent_asid[i_set][w]),
            .key_tag   (i_tag),
            .key_asid  (inv_asid),
            .match     (i_match_vec[w])
         );
      end
   endgenerate

   // ---------------- fill placement ----------------
   logic             fill_go;
   logic [WAYS-1:0]  fill_oh;
   pick_kind_e       fill_kind;
   logic [PTR_W-1:0] rr_ptr [SETS];
   logic [PTR_W-1:0] f_rr;

   // Invalidate has priority over a fill aimed at the same translation.
   assign fill_go = fill_valid && !inv_all &&
                    !(inv_page && inv_vpn == fill_vpn && inv_asid == fill_asid);
   assign f_rr    = rr_ptr[f_set];

   tlbc_fill_pick #(.WAYS(WAYS), .PTR_W(PTR_W)) u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (fill_valid),
      .valid_vec (ent_v[f_set]),
      .match_vec (f_match_vec),
      .rr_ptr    (f_rr),
      .way_oh    (fill_oh),
      .kind      (fill_kind)
   );

   generate
      for (genvar s = 0; s < SETS; s++) begin : g_set
         logic step_s;
         assign step_s = fill_go && (f_set == IDX_W'(s)) && (fill_kind == PICK_ROTATE);
         tlbc_rr_ptr #(.WAYS(WAYS), .PTR_W(PTR_W)) u_rr (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (step_s),
            .ptr   (rr_ptr[s])
         );
      end
   endgenerate

   // ---------------- valid flags ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) ent_v[s] <= '0;
      end else begin
         if (inv_all) begin
            for (int s = 0; s < SETS; s++) ent_v[s] <= '0;
         end else if (inv_page) begin
            ent_v[i_set] <= ent_v[i_set] & ~i_match_vec;
         end
         if (fill_go) begin
            for (int w = 0; w < WAYS; w++) begin
               if (fill_oh[w]) ent_v[f_set][w] <= 1'b1;
            end
         end
      end
   end

   // ---------------- entry payload ----------------
   always_ff @(posedge clk) begin
      if (fill_go) begin
         for (int w = 0; w < WAYS; w++) begin
            if (fill_oh[w]) begin
               ent_tag[f_set][w]  <= f_tag;
               ent_asid[f_set][w] <= fill_asid;
               ent_pfn[f_set][w]  <= fill_pfn;
               ent_wr[f_set][w]   <= fill_writable;
            end
         end
      end
   end

   // ---------------- hit data select ----------------
   logic             l_any;
   logic [PFN_W-1:0] l_pfn;
   logic             l_wr;

   assign l_any = |l_hit_vec;

   always_comb begin
      l_pfn = '0;
      l_wr  = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
         if (l_hit_vec[w]) begin
            l_pfn = l_pfn | ent_pfn[l_set][w];
            l_wr  = l_wr  | ent_wr[l_set][w];
         end
      end
   end

   // ---------------- registered response ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_hit      <= 1'b0;
         lk_paddr    <= '0;
         lk_writable <= 1'b0;
         miss_pulse  <= 1'b0;
         miss_vpn    <= '0;
         miss_asid   <= '0;
      end else begin
         lk_hit      <= lk_valid && l_any;
         lk_paddr    <= (lk_valid && l_any) ? {l_pfn, lk_vaddr[OFS_W-1:0]} : '0;
         lk_writable <= lk_valid && l_any && l_wr;
         miss_pulse  <= lk_valid && !l_any;
         if (lk_valid && !l_any) begin
            miss_vpn  <= l_vpn;
            miss_asid <= lk_asid;
         end
      end
   end

   // ---------------- assertions ----------------
   assert_single_way_R1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> $onehot0(l_hit_vec));

   assert_hit_miss_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_hit && miss_pulse));

   assert_answer_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit || miss_pulse) |-> $past(lk_valid));

   assert_miss_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
      miss_pulse |-> (miss_vpn == $past(l_vpn) && miss_asid == $past(lk_asid)));

   assert_offset_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_paddr[OFS_W-1:0] == $past(lk_vaddr[OFS_W-1:0])));

   assert_no_hit_paddr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_paddr == '0 && !lk_writable));

   assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(inv_all) && lk_valid) |=> !lk_hit);

   assert_inv_beats_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_page && fill_valid && inv_vpn == fill_vpn && inv_asid == fill_asid)
      |=> !(|f_match_vec) || $changed(fill_vpn) || $changed(fill_asid));

endmodule

// File: tb/sim_tlb_asid_cache.sv
module sim_tlb_asid_cache;

   localparam int SETS = 4, WAYS = 2, VPN_W = 36, ASID_W = 8, PFN_W = 24, OFS_W = 12;

   logic clk = 1'b0;
   logic rst_n;
   always #2 clk = ~clk;

   logic                   lk_valid, fill_valid, fill_writable, inv_page, inv_all;
   logic [VPN_W+OFS_W-1:0] lk_vaddr;
   logic [ASID_W-1:0]      lk_asid, fill_asid, inv_asid;
   logic [VPN_W-1:0]       fill_vpn, inv_vpn;
   logic [PFN_W-1:0]       fill_pfn;
   logic                   lk_hit, lk_writable, miss_pulse;
   logic [PFN_W+OFS_W-1:0] lk_paddr;
   logic [VPN_W-1:0]       miss_vpn;
   logic [ASID_W-1:0]      miss_asid;

   tlb_asid_cache #(.SETS(SETS), .WAYS(WAYS), .VPN_W(VPN_W), .ASID_W(ASID_W),
                    .PFN_W(PFN_W), .OFS_W(OFS_W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
      .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_writable(lk_writable),
      .miss_pulse(miss_pulse), .miss_vpn(miss_vpn), .miss_asid(miss_asid),
      .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
      .fill_pfn(fill_pfn), .fill_writable(fill_writable),
      .inv_page(inv_page), .inv_vpn(inv_vpn), .inv_asid(inv_asid), .inv_all(inv_all)
   );

   int n_tests = 0, n_fail = 0;

   // reference model of the entries
   logic             m_v    [SETS][WAYS];
   logic [VPN_W-1:0] m_vpn  [SETS][WAYS];
   logic [ASID_W-1:0] m_asid[SETS][WAYS];
   logic [PFN_W-1:0] m_pfn  [SETS][WAYS];
   logic             m_wr   [SETS][WAYS];
   int               m_rr   [SETS];

   function automatic int set_of(input logic [VPN_W-1:0] v);
      return int'(v % SETS);
   endfunction

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic idle();
      lk_valid = 0; fill_valid = 0; inv_page = 0; inv_all = 0;
   endtask

   // One cycle: predict from the pre-edge model, update model, check after the edge.
   task automatic step(input string tag);
      logic e_hit, e_miss, e_wr;
      logic [PFN_W+OFS_W-1:0] e_pa;
      logic [VPN_W-1:0] lv;
      int s, fw, rot;
      logic drop;
      e_hit = 0; e_wr = 0; e_pa = '0;
      lv = lk_vaddr[VPN_W+OFS_W-1:OFS_W];
      if (lk_valid) begin
         s = set_of(lv);
         for (int w = 0; w < WAYS; w++)
            if (m_v[s][w] && m_vpn[s][w] == lv && m_asid[s][w] == lk_asid) begin
               e_hit = 1; e_wr = m_wr[s][w]; e_pa = {m_pfn[s][w], lk_vaddr[OFS_W-1:0]};
            end
      end
      e_miss = lk_valid && !e_hit;
      // fill placement on old state
      fw = -1; rot = 0;
      s = set_of(fill_vpn);
      for (int w = 0; w < WAYS; w++)
         if (m_v[s][w] && m_vpn[s][w] == fill_vpn && m_asid[s][w] == fill_asid) fw = w;
      if (fw < 0)
         for (int w = WAYS - 1; w >= 0; w--) if (!m_v[s][w]) fw = w;
      if (fw < 0) begin fw = m_rr[s]; rot = 1; end
      drop = inv_all || (inv_page && inv_vpn == fill_vpn && inv_asid == fill_asid);
      if (inv_all) begin
         for (int a = 0; a < SETS; a++) for (int w = 0; w < WAYS; w++) m_v[a][w] = 0;
      end else if (inv_page) begin
         for (int w = 0; w < WAYS; w++)
            if (m_vpn[set_of(inv_vpn)][w] == inv_vpn && m_asid[set_of(inv_vpn)][w] == inv_asid)
               m_v[set_of(inv_vpn)][w] = 0;
      end
      if (fill_valid && !drop) begin
         m_v[s][fw] = 1; m_vpn[s][fw] = fill_vpn; m_asid[s][fw] = fill_asid;
         m_pfn[s][fw] = fill_pfn; m_wr[s][fw] = fill_writable;
         if (rot) m_rr[s] = (m_rr[s] + 1) % WAYS;
      end
      @(posedge clk);
      @(negedge clk);
      chk(tag, "lk_hit", lk_hit, e_hit);
      chk(tag, "miss_pulse", miss_pulse, e_miss);
      chk(tag, "lk_paddr", lk_paddr, e_pa);
      chk(tag, "lk_writable", lk_writable, e_wr);
      if (e_miss) begin
         chk(tag, "miss_vpn", miss_vpn, lv);
         chk(tag, "miss_asid", miss_asid, lk_asid);
      end
      idle();
   endtask

   task automatic look(input string tag, input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                       input logic [OFS_W-1:0] ofs);
      lk_valid = 1; lk_vaddr = {v, ofs}; lk_asid = a;
      step(tag);
   endtask

   task automatic put(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                      input logic [PFN_W-1:0] p, input logic wr);
      fill_valid = 1; fill_vpn = v; fill_asid = a; fill_pfn = p; fill_writable = wr;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 0; idle();
      lk_vaddr = '0; lk_asid = '0; fill_vpn = '0; fill_asid = '0; fill_pfn = '0;
      fill_writable = 0; inv_vpn = '0; inv_asid = '0;
      for (int a = 0; a < SETS; a++) begin
         m_rr[a] = 0;
         for (int w = 0; w < WAYS; w++) begin
            m_v[a][w] = 0; m_vpn[a][w] = '0; m_asid[a][w] = '0; m_pfn[a][w] = '0; m_wr[a][w] = 0;
         end
      end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      @(negedge clk);
      chk("R10 reset", "lk_hit", lk_hit, 0);
      chk("R10 reset", "miss_pulse", miss_pulse, 0);
      chk("R10 reset", "lk_paddr", lk_paddr, 0);

      look("R10 cold miss", 36'h10, 8'd1, 12'h123);
      look("R5 miss key", 36'h9_0000_0010, 8'd7, 12'h0);
      step("R2 idle cycle");

      // R11: fill and lookup in one cycle -> old state
      put(36'h10, 8'd1, 24'hABC, 1'b1);
      lk_valid = 1; lk_vaddr = {36'h10, 12'hA3C}; lk_asid = 8'd1;
      step("R11 same-cycle fill");
      look("R2 R4 hit", 36'h10, 8'd1, 12'hA3C);
      look("R3 other id", 36'h10, 8'd2, 12'h5);
      put(36'h10, 8'd2, 24'h55, 1'b0); step("R6 free way");
      look("R3 id two", 36'h10, 8'd2, 12'hFFF);
      look("R3 id one", 36'h10, 8'd1, 12'h001);

      // R6 rotation in set 0: way0 then way1 replaced
      put(36'h20, 8'd1, 24'h202, 1'b1); step("R6 rotate first");
      look("R6 evicted way0", 36'h10, 8'd1, 12'h0);
      look("R6 new entry", 36'h20, 8'd1, 12'h44);
      look("R6 survivor", 36'h10, 8'd2, 12'h0);
      put(36'h30, 8'd1, 24'h303, 1'b0); step("R6 rotate wrap");
      look("R6 evicted way1", 36'h10, 8'd2, 12'h0);
      put(36'h20, 8'd1, 24'h999, 1'b0); step("R6 in place");
      look("R6 refill value", 36'h20, 8'd1, 12'h7);
      look("R6 refill kept other", 36'h30, 8'd1, 12'h7);

      put(36'h11, 8'd1, 24'h111, 1'b1); step("R1 other set fill");
      look("R1 set one hit", 36'h11, 8'd1, 12'h8);
      look("R1 set zero untouched", 36'h30, 8'd1, 12'h8);

      inv_page = 1; inv_vpn = 36'h20; inv_asid = 8'd2; step("R7 wrong id inv");
      look("R7 entry kept", 36'h20, 8'd1, 12'h1);
      inv_page = 1; inv_vpn = 36'h20; inv_asid = 8'd1; step("R7 inv page");
      look("R7 entry gone", 36'h20, 8'd1, 12'h1);
      look("R7 neighbour kept", 36'h30, 8'd1, 12'h1);

      put(36'h42, 8'd3, 24'h4242, 1'b1);
      inv_page = 1; inv_vpn = 36'h42; inv_asid = 8'd3; step("R9 inv vs fill");
      look("R9 fill dropped", 36'h42, 8'd3, 12'h0);
      put(36'h43, 8'd3, 24'h4343, 1'b1); inv_all = 1; step("R9 flush vs fill");
      look("R9 flush dropped fill", 36'h43, 8'd3, 12'h0);

      put(36'h50, 8'd4, 24'h1, 1'b1); step("R8 prep");
      put(36'h51, 8'd4, 24'h2, 1'b1); step("R8 prep");
      inv_all = 1; step("R8 flush");
      look("R8 set0 empty", 36'h50, 8'd4, 12'h0);
      look("R8 set1 empty", 36'h51, 8'd4, 12'h0);

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(99) < 70) begin
            lk_valid = 1;
            lk_vaddr = {36'($urandom_range(23)), 12'($urandom)};
            lk_asid  = 8'($urandom_range(2, 1));
         end
         if ($urandom_range(99) < 30)
            put(36'($urandom_range(23)), 8'($urandom_range(2, 1)), 24'($urandom), 1'($urandom));
         if ($urandom_range(99) < 6) begin
            inv_page = 1;
            inv_vpn  = 36'($urandom_range(23));
            inv_asid = 8'($urandom_range(2, 1));
         end
         if ($urandom_range(999) < 8) inv_all = 1;
         step("R1 random");
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule